// File: doc/BRIEF.md
# Multi-Source Reset Supervisor

This block combines several reset causes into one active-low system reset line. Two digital flags from external supply comparators arrive: one says the supply is above an upper threshold, the other says it is above a lower threshold. The block keeps a two-state supply view with hysteresis.

- While the supply is considered low, the reset is held. Leaving that state needs the upper flag to stay high for a run of consecutive clocks.
- While the supply is considered good, only the lower flag matters. It must stay low for the same filter length before the block drops back into the held state. This way, brief supply dips and the current surge at start-up do not cause false resets.

Single-cycle strobes from an external watchdog underflow and from an illegal-opcode detector each start a stretched reset pulse of fixed length. A new strobe during the pulse restarts the count.

The reset output is low while either the supply hold or the stretched pulse is active. It is meant to drive an open-drain pad, so other devices on the board are reset too. Because it is built only from registers, it changes only just after a clock edge. A small cause register records which sources have fired. Software clears it with a write-one-to-clear strobe.

Top module: `reset_supervisor`

## Requirements
- R1: While `arst_n` is low, `rst_n_o` is 0 and `cause_o` is 3'b001. The cause bit positions are bit 0 = supply-low, bit 1 = watchdog, bit 2 = illegal opcode.
- R2: From the supply-low state, `rst_n_o` goes to 1 on the clock edge that samples `sup_hi_i` high for the FILT_CYCLES-th consecutive time. A cycle with `sup_hi_i` low restarts the run.
- R3: While running, `sup_hi_i` going low while `sup_lo_i` stays high has no effect on `rst_n_o`.
- R4: While running, a run of fewer than FILT_CYCLES consecutive cycles with `sup_lo_i` low leaves `rst_n_o` at 1. On the edge that samples the FILT_CYCLES-th consecutive low, `rst_n_o` goes to 0 and cause bit 0 is set.
- R5: In the supply-low state the reset stays asserted for as long as `sup_hi_i` is low, even when `sup_lo_i` is high.
- R6: A `wdg_uf_i` strobe sampled on an edge drives `rst_n_o` to 0 from that edge for exactly STRETCH_CYCLES cycles, when no other source holds reset. It also sets cause bit 1.
- R7: A `bad_op_i` strobe behaves like R6 and sets cause bit 2.
- R8: A watchdog or opcode strobe that arrives during a stretched pulse restarts it. The reset then stays low for STRETCH_CYCLES cycles after the last strobe.
- R9: With `clr_we_i` high, each bit set in `clr_mask_i` clears the matching cause bit on the next edge. A set condition in the same cycle takes priority over the clear.
- R10: Watchdog and opcode resets never clear any cause bit. In particular, the supply-low flag stays set until it is cleared explicitly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset of the supervisor logic |
| sup_hi_i | input | 1 | Supply is above the upper (rising) threshold |
| sup_lo_i | input | 1 | Supply is above the lower (falling) threshold |
| wdg_uf_i | input | 1 | Watchdog underflow strobe |
| bad_op_i | input | 1 | Illegal opcode or prefix strobe |
| clr_we_i | input | 1 | Cause-register clear strobe |
| clr_mask_i | input | 3 | Bits of the cause register to clear |
| rst_n_o | output | 1 | System reset, active low, for an open-drain pad |
| cause_o | output | 3 | Reset cause flags |

## Verification
The supply flags are driven in several patterns:
- a rising run broken one cycle before completion, which shows that the filter restarts;
- a lower-flag dip one cycle short of the filter length next to one of exactly the filter length, which locates the edge at which the dip becomes a reset;
- the upper flag falling alone, which separates hysteresis from a single threshold.

Single watchdog and opcode strobes measure the stretch length. A second strobe inside the pulse shows restart versus extension. A strobe that coincides with a clear shows set-over-clear priority. A watchdog reset that follows a supply reset shows that the supply flag survives.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;
  typedef enum logic {
    SUP_LOW = 1'b0,
    SUP_RUN = 1'b1
  } sup_state_e;

  localparam int CAUSE_W    = 3;
  localparam int CAUSE_VOLT = 0;
  localparam int CAUSE_WDG  = 1;
  localparam int CAUSE_OPC  = 2;
  localparam logic [CAUSE_W-1:0] CAUSE_RST = 3'b001;
endpackage

// File: rtl/supply_monitor.sv
module supply_monitor
  import rstsup_pkg::*;
#(
  parameter int FILT_CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic above_hi_i,
  input  logic above_lo_i,
  output logic hold_o,
  output logic drop_o
);
  localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  sup_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            qualify;
  logic            done;

  // condition being filtered depends on the current state (hysteresis)
  always_comb begin
    qualify = (state_q == SUP_LOW) ? above_hi_i : !above_lo_i;
    done    = qualify && (cnt_q == LAST);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    drop_o  = 1'b0;
    if (!qualify) begin
      cnt_d = '0;
    end else if (done) begin
      cnt_d = '0;
      if (state_q == SUP_LOW) begin
        state_d = SUP_RUN;
      end else begin
        state_d = SUP_LOW;
        drop_o  = 1'b1;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= SUP_LOW;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hold_o = (state_q == SUP_LOW);
endmodule

// File: rtl/pulse_stretcher.sv
module pulse_stretcher #(
  parameter int LEN  = 16,
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic [NSRC-1:0] events_i,
  output logic            active_o
);
  localparam int SW = $clog2(LEN + 1);
  localparam logic [SW-1:0] LOAD = SW'(LEN);

  logic [SW-1:0] rem_q, rem_d;
  logic          trig;
  logic          rem_en;

  always_comb begin
    trig   = |events_i;
    rem_en = trig || (rem_q != '0);
    rem_d  = trig ? LOAD : (rem_q - 1'b1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign active_o = (rem_q != '0);
endmodule

// File: rtl/cause_register.sv
module cause_register
  import rstsup_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               clr_we_i,
  input  logic [CAUSE_W-1:0] clr_mask_i,
  output logic [CAUSE_W-1:0] cause_o
);
  for (genvar b = 0; b < CAUSE_W; b++) begin : g_bit
    logic flag_q, flag_d, flag_en;

    always_comb begin
      flag_en = set_i[b] || (clr_we_i && clr_mask_i[b]);
      flag_d  = set_i[b];
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        flag_q <= CAUSE_RST[b];
      end else if (flag_en) begin
        flag_q <= flag_d;
      end
    end

    assign cause_o[b] = flag_q;
  end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import rstsup_pkg::*;
#(
  parameter int FILT_CYCLES    = 8,
  parameter int STRETCH_CYCLES = 16
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               sup_hi_i,
  input  logic               sup_lo_i,
  input  logic               wdg_uf_i,
  input  logic               bad_op_i,
  input  logic               clr_we_i,
  input  logic [CAUSE_W-1:0] clr_mask_i,
  output logic               rst_n_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               volt_hold;
  logic               volt_drop;
  logic               pulse_act;
  logic [CAUSE_W-1:0] cause_set;

  supply_monitor #(.FILT_CYCLES(FILT_CYCLES)) u_mon (
    .clk        (clk),
    .arst_n     (arst_n),
    .above_hi_i (sup_hi_i),
    .above_lo_i (sup_lo_i),
    .hold_o     (volt_hold),
    .drop_o     (volt_drop)
  );

  pulse_stretcher #(.LEN(STRETCH_CYCLES), .NSRC(2)) u_str (
    .clk      (clk),
    .arst_n   (arst_n),
    .events_i ({bad_op_i, wdg_uf_i}),
    .active_o (pulse_act)
  );

  always_comb begin
    cause_set             = '0;
    cause_set[CAUSE_VOLT] = volt_drop;
    cause_set[CAUSE_WDG]  = wdg_uf_i;
    cause_set[CAUSE_OPC]  = bad_op_i;
  end

  cause_register u_cause (
    .clk        (clk),
    .arst_n     (arst_n),
    .set_i      (cause_set),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .cause_o    (cause_o)
  );

  // both terms come straight from registers: release happens just after an edge
  assign rst_n_o = !(volt_hold || pulse_act);
endmodule

// File: rtl/rstsup_checker.sv
module rstsup_checker #(
  parameter int STRETCH_CYCLES = 16
) (
  input logic       clk,
  input logic       arst_n,
  input logic       sup_hi_i,
  input logic       sup_lo_i,
  input logic       wdg_uf_i,
  input logic       bad_op_i,
  input logic       clr_we_i,
  input logic [2:0] clr_mask_i,
  input logic       rst_n_o,
  input logic [2:0] cause_o,
  input logic       hold_i
);
  logic [31:0] win_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) win_q <= '0;
    else if (wdg_uf_i || bad_op_i) win_q <= STRETCH_CYCLES;
    else if (win_q != 0) win_q <= win_q - 1;
  end

  a_r1_reset_low: assert property (@(posedge clk) !arst_n |-> !rst_n_o);

  a_r3_hysteresis: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_n_o && sup_lo_i && !wdg_uf_i && !bad_op_i) |=> rst_n_o);

  a_r5_hold_stays: assert property (@(posedge clk) disable iff (!arst_n)
    (hold_i && !sup_hi_i) |=> hold_i);

  a_r5_hold_resets: assert property (@(posedge clk) disable iff (!arst_n)
    hold_i |-> !rst_n_o);

  a_r6_wdg_fires: assert property (@(posedge clk) disable iff (!arst_n)
    wdg_uf_i |=> (!rst_n_o && cause_o[1]));

  a_r7_opc_fires: assert property (@(posedge clk) disable iff (!arst_n)
    bad_op_i |=> (!rst_n_o && cause_o[2]));

  a_r8_min_width: assert property (@(posedge clk) disable iff (!arst_n)
    (win_q != 0) |-> !rst_n_o);

  a_r9_clear_wdg: assert property (@(posedge clk) disable iff (!arst_n)
    (clr_we_i && clr_mask_i[1] && !wdg_uf_i) |=> !cause_o[1]);

  a_r9_clear_opc: assert property (@(posedge clk) disable iff (!arst_n)
    (clr_we_i && clr_mask_i[2] && !bad_op_i) |=> !cause_o[2]);

  a_r10_volt_kept: assert property (@(posedge clk) disable iff (!arst_n)
    (cause_o[0] && !(clr_we_i && clr_mask_i[0])) |=> cause_o[0]);
endmodule

bind reset_supervisor rstsup_checker #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .sup_hi_i   (sup_hi_i),
  .sup_lo_i   (sup_lo_i),
  .wdg_uf_i   (wdg_uf_i),
  .bad_op_i   (bad_op_i),
  .clr_we_i   (clr_we_i),
  .clr_mask_i (clr_mask_i),
  .rst_n_o    (rst_n_o),
  .cause_o    (cause_o),
  .hold_i     (volt_hold)
);

// File: tb/reset_supervisor_tb_top.sv
`timescale 1ns/1ps
module reset_supervisor_tb_top;
  localparam int F = 5;
  localparam int S = 6;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       sup_hi, sup_lo, wdg, bad, clr_we;
  logic [2:0] clr_mask;
  logic       rst_n;
  logic [2:0] cause;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";

  // reference model state
  bit       m_low;
  int       m_cnt;
  int       m_s;
  bit [2:0] m_cause;

  always #2.5 clk = ~clk;

  reset_supervisor #(.FILT_CYCLES(F), .STRETCH_CYCLES(S)) dut_i (
    .clk(clk), .arst_n(arst_n), .sup_hi_i(sup_hi), .sup_lo_i(sup_lo),
    .wdg_uf_i(wdg), .bad_op_i(bad), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .rst_n_o(rst_n), .cause_o(cause)
  );

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_low = 1; m_cnt = 0; m_s = 0; m_cause = 3'b001;
    end else begin
      bit [2:0] nc;
      nc = clr_we ? (m_cause & ~clr_mask) : m_cause;
      if (m_low) begin
        if (!sup_hi) m_cnt = 0;
        else if (m_cnt == F - 1) begin m_low = 0; m_cnt = 0; end
        else m_cnt++;
      end else begin
        if (sup_lo) m_cnt = 0;
        else if (m_cnt == F - 1) begin m_low = 1; m_cnt = 0; nc[0] = 1; end
        else m_cnt++;
      end
      if (wdg) nc[1] = 1;
      if (bad) nc[2] = 1;
      if (wdg || bad) m_s = S;
      else if (m_s > 0) m_s--;
      m_cause = nc;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk({phase, " rst_n_o"}, rst_n, (m_low || m_s > 0) ? 0 : 1);
    chk({phase, " cause_o"}, cause, m_cause);
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    arst_n = 0; sup_hi = 0; sup_lo = 0; wdg = 0; bad = 0; clr_we = 0; clr_mask = 0;
    #7;
    chk("R1 reset rst", rst_n, 0);
    chk("R1 reset cause", cause, 3'b001);
    tick(2);
    arst_n = 1;
    // R2: broken run then full run
    phase = "R2";
    sup_hi = 1; sup_lo = 1;
    tick(F - 1);
    sup_hi = 0; tick(1);
    sup_hi = 1; tick(F - 1);
    chk("R2 not yet released", rst_n, 0);
    tick(1);
    chk("R2 released after filter", rst_n, 1);
    // R9: clear the power-on flag
    phase = "R9";
    clr_we = 1; clr_mask = 3'b001; tick(1);
    clr_we = 0; clr_mask = 0;
    chk("R9 volt flag cleared", cause, 3'b000);
    // R3: upper flag alone falls
    phase = "R3";
    sup_hi = 0; tick(12);
    chk("R3 hysteresis no reset", rst_n, 1);
    // R4: short dip, then full dip
    phase = "R4";
    sup_lo = 0; tick(F - 1);
    sup_lo = 1; tick(3);
    chk("R4 short dip ignored", rst_n, 1);
    chk("R4 short dip no cause", cause, 3'b000);
    sup_lo = 0; tick(F - 1);
    chk("R4 before filter end", rst_n, 1);
    tick(1);
    chk("R4 dip resets", rst_n, 0);
    chk("R4 volt cause", cause, 3'b001);
    // R5: held while upper flag low
    phase = "R5";
    tick(6);
    sup_lo = 1; tick(10);
    chk("R5 held with lower flag high", rst_n, 0);
    sup_hi = 1; tick(F);
    chk("R5 release after filter", rst_n, 1);
    // R10: watchdog reset keeps volt flag
    phase = "R10";
    wdg = 1; tick(1); wdg = 0;
    chk("R10 volt flag survives", cause[0], 1);
    tick(S + 2);
    chk("R10 flags after wdg", cause, 3'b011);
    clr_we = 1; clr_mask = 3'b111; tick(1);
    clr_we = 0; clr_mask = 0;
    // R6: watchdog pulse width
    phase = "R6";
    wdg = 1; tick(1); wdg = 0;
    chk("R6 asserted", rst_n, 0);
    tick(S - 1);
    chk("R6 still low at last cycle", rst_n, 0);
    tick(1);
    chk("R6 released after S", rst_n, 1);
    chk("R6 cause", cause, 3'b010);
    // R7: opcode pulse
    phase = "R7";
    bad = 1; tick(1); bad = 0;
    chk("R7 asserted", rst_n, 0);
    tick(S);
    chk("R7 released", rst_n, 1);
    chk("R7 cause", cause, 3'b110);
    // R8: restart during stretch
    phase = "R8";
    wdg = 1; tick(1); wdg = 0;
    tick(3);
    bad = 1; tick(1); bad = 0;
    tick(S - 1);
    chk("R8 extended pulse low", rst_n, 0);
    tick(1);
    chk("R8 released", rst_n, 1);
    // R9: set beats clear
    phase = "R9";
    clr_we = 1; clr_mask = 3'b010; wdg = 1; tick(1);
    clr_we = 0; clr_mask = 0; wdg = 0;
    chk("R9 set wins over clear", cause[1], 1);
    tick(S + 2);
    clr_we = 1; clr_mask = 3'b100; tick(1);
    clr_we = 0; clr_mask = 0;
    chk("R9 opcode cleared only", cause, 3'b010);
    tick(3);
    summary();
  end
endmodule